// File: doc/BRIEF.md
# Single-Compare PWM Timer

This block is an 8-bit counter with one compare channel, intended as a general-purpose timing resource. A clock-select field picks what advances the counter: nothing (stopped), every system clock, one of four taps of a free-running 10-bit prescaler, or a synchronized edge of an external event pin. The same comparator serves four counting modes: a free-running up count, an up count that reloads to zero on a compare match, a single-slope PWM, and a dual-slope (up then down) phase-correct PWM.

A small register port (two address bits, write strobe, combinational readback) gives access to the control fields, the counter, the compare value and two sticky flags. One flag marks an overflow and the other marks a compare match; both are brought out as interrupt request lines and are cleared by writing a one to them. A registered waveform output follows the compare events in the non-PWM modes and the duty cycle in the PWM modes. In the PWM modes the compare value is double-buffered so that a new duty cycle never takes effect in mid-period.

Top module: `cmp_timer`

## Requirements
- R1: After reset all four registers read 0, the waveform output is low and both flag outputs are low.
- R2: Register map: address 0 is control, read as {1'b0, out_mode[6:5], mode[4:3], csel[2:0]} with bit 7 always read 0; address 1 is the counter; address 2 returns the last value written to the compare register; address 3 reads {6'b0, match flag bit 1, overflow flag bit 0}. Writes take effect on the clock edge that samples the write strobe.
- R3: csel 0 stops the counter; csel 1..5 advance it once every 1, 8, 64, 256 and 1024 clock cycles.
- R4: csel 7 counts rising edges and csel 6 counts falling edges of the external pin; each qualifying pin transition yields exactly one count, applied on the third rising clock edge after the pin changes, and edges of the other polarity yield none.
- R5: Mode 0 (normal): the counter counts up, wraps from 0xFF to 0x00, and the overflow flag is set on that same edge.
- R6: Mode 1 (reload on match): a count step taken while the counter equals the compare value loads 0 instead of incrementing.
- R7: In every mode, a count step taken while the counter equals the active compare value sets the match flag.
- R8: In modes 0 and 1, out_mode 0 holds the waveform low, 1 toggles it, 2 clears it and 3 sets it on each match step.
- R9: Mode 2 (fast PWM) counts 0..0xFF and wraps, setting the overflow flag at the wrap; with out_mode 2 the waveform is high exactly while counter < compare, with out_mode 3 it is the inverse, and with out_mode 0 or 1 it is low.
- R10: Mode 3 (phase-correct PWM) counts up to 0xFF, then down to 0x00, then up again, visiting each turning value once; the overflow flag is set when the count reaches 0x00 going down; the waveform rule of R9 applies, giving 199 high cycles in 510 for a compare value of 100.
- R11: In modes 2 and 3 a compare write is held in a buffer and becomes active only on a count step from 0xFF (mode 2) or from 0xFF or 0x00 (mode 3); in modes 0 and 1 it is active at once.
- R12: Writing 1 to flag bit 0 or bit 1 at address 3 clears that flag; writing 0 leaves it unchanged; a flag set event in the same cycle wins over the clear.
- R13: A counter write overrides the count step of that cycle: the written value is held exactly, with no overflow or match event from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 1 | External event pin, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| wave_out | output | 1 | Registered waveform output |
| ovf_irq | output | 1 | Sticky overflow flag / interrupt request |
| cmp_irq | output | 1 | Sticky compare-match flag / interrupt request |

## Verification
Every register write and every count step lands on the clock edge that samples it, so the counter, both flags and the waveform are checked on the sample taken half a cycle after the edge that was counted; the bench drives and samples on the falling edge and advances by an exact number of rising edges before each check. An external pin transition is due on the third rising edge (two synchronizer stages plus the edge-detect register), and the bench checks that the count is still unchanged one edge earlier. Prescaled rates are checked as an exact count difference over a window of 4 x divider edges, which holds for any prescaler phase, and the PWM duty is checked by counting high samples over one full period.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_CTC    = 2'd1,
        MODE_FAST   = 2'd2,
        MODE_PHASE  = 2'd3
    } tc_mode_e;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_TOGGLE = 2'd1,
        OUT_CLEAR  = 2'd2,
        OUT_SET    = 2'd3
    } tc_out_e;

    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_DIV1     = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } tc_csel_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_CMP   = 2'd2;
    localparam logic [1:0] ADDR_FLAG  = 2'd3;

    typedef struct packed {
        tc_out_e  out_mode;
        tc_mode_e mode;
        tc_csel_e csel;
    } tc_ctrl_t;

    localparam int CTRL_W = $bits(tc_ctrl_t);

endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    // SYNC_N synchronizer stages plus one history stage for edge detect
    localparam int LEN = SYNC_N + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise =  sh_q[LEN-2] & ~sh_q[LEN-1];
    assign fall = ~sh_q[LEN-2] &  sh_q[LEN-1];

endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler
    import tc_pkg::*;
#(
    parameter int PSC_W = 10
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tc_csel_e csel,
    input  logic     ext_rise,
    input  logic     ext_fall,
    output logic     tick
);
    // tap positions: divide by 2**L
    localparam int L8    = 3;
    localparam int L64   = 6;
    localparam int L256  = 8;
    localparam int L1024 = PSC_W;
    localparam logic [PSC_W-1:0] ONE = {{(PSC_W-1){1'b0}}, 1'b1};

    logic [PSC_W-1:0] psc_d, psc_q;
    logic [3:0]       tap;

    always_comb begin
        psc_d  = psc_q + ONE;
        tap[0] = &psc_q[L8-1:0];
        tap[1] = &psc_q[L64-1:0];
        tap[2] = &psc_q[L256-1:0];
        tap[3] = &psc_q[L1024-1:0];
        case (csel)
            CS_DIV1:     tick = 1'b1;
            CS_DIV8:     tick = tap[0];
            CS_DIV64:    tick = tap[1];
            CS_DIV256:   tick = tap[2];
            CS_DIV1024:  tick = tap[3];
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
            default:     tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

endmodule

// File: rtl/tc_count_unit.sv
module tc_count_unit
    import tc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tc_mode_e     mode,
    input  tc_out_e      out_mode,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] cmp_shadow,
    output logic [W-1:0] cmp_act,
    output logic         wave,
    output logic         ovf_evt,
    output logic         cmp_evt
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] shadow;
        logic [W-1:0] act;
        logic         dn;
        logic         wave;
    } cu_st_t;

    cu_st_t st_d, st_q;
    logic   pwm, at_top, at_bot, hit, below;

    always_comb begin
        st_d    = st_q;
        ovf_evt = 1'b0;
        cmp_evt = 1'b0;
        pwm     = (mode == MODE_FAST) || (mode == MODE_PHASE);
        at_top  = (st_q.cnt == MAXV);
        at_bot  = (st_q.cnt == '0);
        hit     = (st_q.cnt == st_q.act);

        if (cmp_we) begin
            st_d.shadow = cmp_wdata;
            if (!pwm) st_d.act = cmp_wdata;
        end
        if (mode != MODE_PHASE) st_d.dn = 1'b0;

        if (cnt_we) begin
            st_d.cnt = cnt_wdata;
        end else if (tick) begin
            cmp_evt = hit;
            case (mode)
                MODE_CTC: begin
                    st_d.cnt = hit ? '0 : st_q.cnt + ONE;
                    ovf_evt  = at_top;
                end
                MODE_FAST: begin
                    st_d.cnt = st_q.cnt + ONE;
                    ovf_evt  = at_top;
                    if (at_top) st_d.act = st_d.shadow;
                end
                MODE_PHASE: begin
                    if (!st_q.dn) begin
                        if (at_top) begin
                            st_d.dn  = 1'b1;
                            st_d.cnt = MAXV - ONE;
                        end else begin
                            st_d.cnt = st_q.cnt + ONE;
                        end
                    end else if (at_bot) begin
                        st_d.dn  = 1'b0;
                        st_d.cnt = ONE;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                        ovf_evt  = (st_q.cnt == ONE);
                    end
                    if (at_top || at_bot) st_d.act = st_d.shadow;
                end
                default: begin
                    st_d.cnt = st_q.cnt + ONE;
                    ovf_evt  = at_top;
                end
            endcase
        end

        below = (st_d.cnt < st_d.act);
        if (pwm) begin
            case (out_mode)
                OUT_CLEAR: st_d.wave = below;
                OUT_SET:   st_d.wave = ~below;
                default:   st_d.wave = 1'b0;
            endcase
        end else if (out_mode == OUT_OFF) begin
            st_d.wave = 1'b0;
        end else if (cmp_evt) begin
            case (out_mode)
                OUT_TOGGLE: st_d.wave = ~st_q.wave;
                OUT_CLEAR:  st_d.wave = 1'b0;
                default:    st_d.wave = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count      = st_q.cnt;
    assign cmp_shadow = st_q.shadow;
    assign cmp_act    = st_q.act;
    assign wave       = st_q.wave;

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tc_pkg::*;
#(
    parameter int W      = 8,
    parameter int PSC_W  = 10,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_in,
    input  logic         bus_we,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         wave_out,
    output logic         ovf_irq,
    output logic         cmp_irq
);
    typedef struct packed {
        tc_ctrl_t ctrl;
        logic     ovf;
        logic     cmp;
    } top_st_t;

    top_st_t      st_d, st_q;
    tc_ctrl_t     ctrl;
    logic         ctrl_we, cnt_we, cmp_we, flag_we;
    logic         tick, ext_rise, ext_fall;
    logic         ovf_evt, cmp_evt;
    logic [W-1:0] count, cmp_shadow, cmp_act;

    assign ctrl    = st_q.ctrl;
    assign ctrl_we = bus_we && (bus_addr == ADDR_CTRL);
    assign cnt_we  = bus_we && (bus_addr == ADDR_COUNT);
    assign cmp_we  = bus_we && (bus_addr == ADDR_CMP);
    assign flag_we = bus_we && (bus_addr == ADDR_FLAG);

    tc_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_in),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    tc_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .csel    (ctrl.csel),
        .ext_rise(ext_rise),
        .ext_fall(ext_fall),
        .tick    (tick)
    );

    tc_count_unit #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (ctrl.mode),
        .out_mode  (ctrl.out_mode),
        .cnt_we    (cnt_we),
        .cnt_wdata (bus_wdata),
        .cmp_we    (cmp_we),
        .cmp_wdata (bus_wdata),
        .count     (count),
        .cmp_shadow(cmp_shadow),
        .cmp_act   (cmp_act),
        .wave      (wave_out),
        .ovf_evt   (ovf_evt),
        .cmp_evt   (cmp_evt)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_we) st_d.ctrl = tc_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        st_d.ovf = (st_q.ovf && !(flag_we && bus_wdata[0])) || ovf_evt;
        st_d.cmp = (st_q.cmp && !(flag_we && bus_wdata[1])) || cmp_evt;
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = {{(W-CTRL_W){1'b0}}, st_q.ctrl};
            ADDR_COUNT: bus_rdata = count;
            ADDR_CMP:   bus_rdata = cmp_shadow;
            default:    bus_rdata = {{(W-2){1'b0}}, st_q.cmp, st_q.ovf};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_irq = st_q.ovf;
    assign cmp_irq = st_q.cmp;

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
    import tc_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input tc_ctrl_t     ctrl,
    input logic         tick,
    input logic [W-1:0] count,
    input logic [W-1:0] cmp_act,
    input logic         wave,
    input logic         ovf_flag,
    input logic         cmp_flag,
    input logic         ctrl_we,
    input logic         cnt_we,
    input logic         flag_we,
    input logic [W-1:0] wdata
);
    localparam logic [W-1:0] MAXV = '1;

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.csel == CS_STOP && !cnt_we) |=> $stable(count));

    // R4
    ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.csel == CS_EXT_RISE && tick && !ctrl_we) |=> !tick);

    // R5
    normal_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_NORMAL && tick && count == MAXV && !cnt_we)
        |=> (count == '0 && ovf_flag));

    // R6
    ctc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_CTC && tick && count == cmp_act && !cnt_we)
        |=> (count == '0 && cmp_flag));

    // R9
    fast_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_FAST && ctrl.out_mode == OUT_CLEAR && !ctrl_we)
        |=> (wave == (count < cmp_act)));

    // R10
    phase_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == MODE_PHASE && tick && count == MAXV && !cnt_we)
        |=> (count == MAXV - 1'b1));

    // R12
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wdata[0] && !tick) |=> !ovf_flag);

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(flag_we && wdata[0])) |=> ovf_flag);

endmodule

bind cmp_timer cmp_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .tick    (tick),
    .count   (count),
    .cmp_act (cmp_act),
    .wave    (wave_out),
    .ovf_flag(ovf_irq),
    .cmp_flag(cmp_irq),
    .ctrl_we (ctrl_we),
    .cnt_we  (cnt_we),
    .flag_we (flag_we),
    .wdata   (bus_wdata)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_in = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       wave_out, ovf_irq, cmp_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    cmp_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_in),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .wave_out (wave_out),
        .ovf_irq  (ovf_irq),
        .cmp_irq  (cmp_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called just after a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic high_cycles(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (wave_out) hi++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 register after reset", v, 0);
        end
        check("R1 wave after reset", wave_out, 0);
        check("R1 ovf after reset", ovf_irq, 0);
        check("R1 cmp after reset", cmp_irq, 0);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(2'd0, 8'hB8);
        rd(2'd0, v);
        check("R2 control readback, bit7 zero", v, 8'h38);
        wr(2'd0, 8'h00);
        rd(2'd0, v);
        check("R2 control cleared", v, 8'h00);
    endtask

    task automatic t_normal();
        logic [7:0] v;
        wr(2'd1, 8'hFD);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h01);
        rd(2'd1, v);
        check("R13 written count held", v, 8'hFD);
        step(2);
        rd(2'd1, v);
        check("R5 count before wrap", v, 8'hFF);
        check("R5 no overflow before wrap", ovf_irq, 0);
        step(1);
        rd(2'd1, v);
        check("R5 wrap to zero", v, 8'h00);
        check("R5 overflow at wrap", ovf_irq, 1);
        rd(2'd3, v);
        check("R2 flag register bit0", v, 8'h01);
        step(10);
        rd(2'd1, v);
        check("R3 clk/1 rate", v, 8'h0A);
    endtask

    task automatic t_flags();
        wr(2'd3, 8'h00);
        check("R12 write 0 keeps ovf", ovf_irq, 1);
        wr(2'd3, 8'h02);
        check("R12 clearing match bit keeps ovf", ovf_irq, 1);
        wr(2'd3, 8'h01);
        check("R12 write 1 clears ovf", ovf_irq, 0);
    endtask

    task automatic t_override();
        logic [7:0] v;
        wr(2'd1, 8'h40);
        rd(2'd1, v);
        check("R13 write overrides step", v, 8'h40);
        step(1);
        rd(2'd1, v);
        check("R13 counting resumes", v, 8'h41);
        wr(2'd0, 8'h00);
        rd(2'd1, v);
        step(20);
        begin
            logic [7:0] v2;
            rd(2'd1, v2);
            check("R3 stopped counter holds", v2, v);
        end
    endtask

    task automatic t_prescale();
        logic [7:0] c0, c1;
        for (int s = 2; s <= 5; s++) begin
            int div;
            div = (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
            wr(2'd0, s[7:0]);
            rd(2'd1, c0);
            step(4 * div);
            rd(2'd1, c1);
            check($sformatf("R3 divide by %0d", div), 8'(c1 - c0), 4);
        end
    endtask

    task automatic t_ctc();
        logic [7:0] v;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h05);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h29);   // toggle, reload mode, clk/1
        step(5);
        rd(2'd1, v);
        check("R6 count reaches compare", v, 5);
        check("R7 no match yet", cmp_irq, 0);
        step(1);
        rd(2'd1, v);
        check("R6 reload to zero", v, 0);
        check("R7 match flag set", cmp_irq, 1);
        check("R8 toggle high", wave_out, 1);
        step(6);
        check("R8 toggle low", wave_out, 0);
        wr(2'd0, 8'h69);   // set on match
        step(5);
        rd(2'd1, v);
        check("R6 period of six", v, 0);
        check("R8 set on match", wave_out, 1);
        step(6);
        check("R8 set stays high", wave_out, 1);
        wr(2'd0, 8'h49);   // clear on match
        step(5);
        check("R8 clear on match", wave_out, 0);
    endtask

    task automatic t_fast();
        logic [7:0] v;
        int hi;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd64);
        wr(2'd0, 8'h50);   // non-inverting, fast PWM, stopped
        wr(2'd1, 8'd100);
        check("R9 high only below compare", wave_out, 0);
        wr(2'd2, 8'd200);
        rd(2'd2, v);
        check("R11 compare readback", v, 200);
        step(3);
        check("R11 buffered value not yet active", wave_out, 0);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h51);
        step(1);
        rd(2'd1, v);
        check("R9 wrap from top", v, 0);
        check("R11 buffer loads at top", wave_out, 1);
        check("R9 overflow at wrap", ovf_irq, 1);
        step(20);
        high_cycles(256, hi);
        check("R9 non-inverting duty", hi, 200);
        wr(2'd0, 8'h71);
        step(4);
        high_cycles(256, hi);
        check("R9 inverting duty", hi, 56);
        wr(2'd0, 8'h11);
        step(2);
        high_cycles(256, hi);
        check("R9 disconnected output", hi, 0);
    endtask

    task automatic t_phase();
        logic [7:0] v;
        int hi;
        wr(2'd0, 8'h50);
        wr(2'd2, 8'd100);
        wr(2'd1, 8'hFD);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h59);   // non-inverting, phase-correct, clk/1
        step(2);
        rd(2'd1, v);
        check("R10 up to top", v, 8'hFF);
        step(1);
        rd(2'd1, v);
        check("R10 turns down", v, 8'hFE);
        step(1);
        rd(2'd1, v);
        check("R10 keeps going down", v, 8'hFD);
        wr(2'd1, 8'h02);
        step(1);
        check("R10 no overflow above bottom", ovf_irq, 0);
        step(1);
        rd(2'd1, v);
        check("R10 reaches bottom", v, 0);
        check("R10 overflow at bottom", ovf_irq, 1);
        step(1);
        rd(2'd1, v);
        check("R10 turns up", v, 1);
        step(520);
        high_cycles(510, hi);
        check("R10 symmetric duty", hi, 199);
    endtask

    task automatic t_ext();
        logic [7:0] c0, v;
        wr(2'd0, 8'h07);   // normal, external rising
        rd(2'd1, c0);
        ext_in = 1'b1;
        step(2);
        rd(2'd1, v);
        check("R4 not yet counted", v, c0);
        step(1);
        rd(2'd1, v);
        check("R4 rising edge counted", v, 8'(c0 + 1));
        step(20);
        rd(2'd1, v);
        check("R4 held level counts once", v, 8'(c0 + 1));
        ext_in = 1'b0;
        step(10);
        rd(2'd1, v);
        check("R4 falling edge ignored", v, 8'(c0 + 1));
        wr(2'd0, 8'h06);   // external falling
        ext_in = 1'b1;
        step(10);
        rd(2'd1, v);
        check("R4 rising edge ignored", v, 8'(c0 + 1));
        ext_in = 1'b0;
        step(3);
        rd(2'd1, v);
        check("R4 falling edge counted", v, 8'(c0 + 2));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=0 exp=1");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regmap();
        t_normal();
        t_flags();
        t_override();
        t_prescale();
        t_ctc();
        t_fast();
        t_phase();
        t_ext();
        finish_run();
    end

endmodule